// File: doc/BRIEF.md
# Byte-Stream Command Bridge to APB

This block lets an external host reach a 32-bit memory-mapped APB bus through nothing more than a byte pipe. Command bytes enter on an 8-bit AXI-Stream slave port, which a UART receiver or any other byte-serial receiver can feed. The block assembles each command frame, runs one or more APB transfers, and returns response bytes on an 8-bit AXI-Stream master port that feeds the matching transmitter.

A frame begins with an operation byte. Four address bytes follow, then a length byte, then the write payload for write operations. Single and burst transfers are supported. A burst walks through consecutive word addresses. Read data comes back as bytes, and a closing status byte follows. The bridge processes one frame at a time. It stops accepting input while the bus is busy or while a response is being sent, so a front end that honours ready never loses a byte.

Top module: `cmd_bus_bridge`

## Requirements
- R1: During and after reset, with no input, `psel`, `penable` and `m_tvalid` are low, and once reset is released `s_tready` is high (waiting for an operation byte).
- R2: A frame is: operation byte, four address bytes with the most significant byte first, then one length byte. Operation codes are 0x01 single write, 0x02 single read, 0x03 burst write and 0x04 burst read.
- R3: For a write, each word's four payload bytes follow the length byte, most significant byte first. Each word is written by one APB write, with `pwdata` equal to the assembled word. After the last word, one status byte is returned: 0xAC on success.
- R4: A single read performs one APB read and returns the four bytes of `prdata` (most significant first) followed by status 0xAC. For single operations the length byte is consumed but its value has no effect.
- R5: For burst operations, a length byte of N gives N+1 APB transfers. The first transfer uses the frame address, and each later transfer uses an address 4 higher than the one before.
- R6: Each APB transfer has one setup cycle (`psel` high, `penable` low) followed by access cycles (`psel` and `penable` high). `paddr`, `pwrite` and `pwdata` stay stable until a cycle with `pready` high.
- R7: If any transfer in a frame completes with `pslverr` high, the status byte is 0xEE instead of 0xAC. The remaining transfers of a burst still run, and every read word is still returned.
- R8: An operation byte other than 0x01 to 0x04 starts no APB transfer. It produces exactly one response byte, 0xEE, and the next byte is again taken as an operation byte.
- R9: `s_tready` is low whenever an APB transfer is in progress or a response byte is pending. No accepted byte is lost, and after every frame the bridge returns to waiting for an operation byte.
- R10: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and `m_tdata` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_tdata | input | 8 | Command byte |
| s_tvalid | input | 1 | Command byte valid |
| s_tready | output | 1 | Bridge accepts a command byte |
| m_tdata | output | 8 | Response byte |
| m_tvalid | output | 1 | Response byte valid |
| m_tready | input | 1 | Receiver accepts response byte |
| paddr | output | 32 | APB address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (access phase) |
| pwrite | output | 1 | APB write direction |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB transfer completion |
| pslverr | input | 1 | APB slave error |

## Verification
The assertions check the following on every cycle: the APB phase order and the holding of bus signals during wait states; the rule that input is refused while the bus or the response path is busy; the stream hold rule on the response port; and the immediate 0xEE reply to an unknown operation byte. Several behaviours can only be shown by the bench scenarios. These are the assembly of addresses and payload words from bytes, the increment across bursts of many words, the number and order of returned bytes, the status chosen after a slave error partway through a burst, and the fact that a single operation ignores its length byte. The scenarios cover these with wait states and backpressure on the response port.

// File: rtl/cmdbr_pkg.sv
package cmdbr_pkg;

  localparam logic [7:0] OPC_WR_ONE   = 8'h01;
  localparam logic [7:0] OPC_RD_ONE   = 8'h02;
  localparam logic [7:0] OPC_WR_BURST = 8'h03;
  localparam logic [7:0] OPC_RD_BURST = 8'h04;

  localparam logic [7:0] RESP_OK   = 8'hAC;
  localparam logic [7:0] RESP_FAIL = 8'hEE;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_LEN,
    ST_WDAT,
    ST_BUS,
    ST_RDOUT,
    ST_STAT
  } frame_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACCESS
  } bus_phase_e;

  function automatic logic opc_known(input logic [7:0] opc);
    return (opc == OPC_WR_ONE) || (opc == OPC_RD_ONE) ||
           (opc == OPC_WR_BURST) || (opc == OPC_RD_BURST);
  endfunction

  function automatic logic [7:0] status_code(input logic failed);
    return failed ? RESP_FAIL : RESP_OK;
  endfunction

endpackage

// File: rtl/cmdbr_apb_master.sv
module cmdbr_apb_master
  import cmdbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);

  bus_phase_e        phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic              req_en;

  assign req_en = (phase_q == PH_IDLE) && start;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (start) phase_d = PH_SETUP;
      PH_SETUP:  phase_d = PH_ACCESS;
      PH_ACCESS: if (pready) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (req_en) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        write_q <= req_write;
      end
    end
  end

  assign psel      = (phase_q != PH_IDLE);
  assign penable   = (phase_q == PH_ACCESS);
  assign paddr     = addr_q;
  assign pwrite    = write_q;
  assign pwdata    = wdata_q;
  assign done      = penable && pready;
  assign rsp_rdata = prdata;
  assign rsp_err   = pslverr;

  // R6: one setup cycle, then access
  p_setup_then_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable));

  // R6: bus signals held through wait states
  p_hold_until_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |=>
      (psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  // R9: a new request never arrives while a transfer is running
  p_start_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !psel);

endmodule

// File: rtl/cmdbr_resp_ser.sv
module cmdbr_resp_ser #(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [DATA_W-1:0]                load_word,
  input  logic [$clog2(DATA_W/8+1)-1:0]    load_cnt,
  output logic                             done,
  output logic [7:0]                       m_tdata,
  output logic                             m_tvalid,
  input  logic                             m_tready
);

  localparam int WBYTES = DATA_W / 8;
  localparam int CNT_W  = $clog2(WBYTES + 1);

  logic [DATA_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              hs;

  assign hs       = m_tvalid && m_tready;
  assign m_tvalid = (cnt_q != '0);
  assign m_tdata  = word_q[DATA_W-1 -: 8];
  assign done     = hs && (cnt_q == CNT_W'(1));

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (load) begin
      word_d = load_word;
      cnt_d  = load_cnt;
    end else if (hs) begin
      word_d = {word_q[DATA_W-9:0], 8'h00};
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  // R10: stream hold rule under backpressure
  p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

  // R9: no response byte overwritten before it leaves
  p_load_when_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!m_tvalid || done));

endmodule

// File: rtl/cmd_bus_bridge.sv
module cmd_bus_bridge
  import cmdbr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [7:0]        m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [ADDR_W-1:0] paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);

  localparam int WBYTES = DATA_W / 8;
  localparam int ABYTES = ADDR_W / 8;
  localparam int BC_W   = $clog2(ABYTES + WBYTES);
  localparam int CNT_W  = $clog2(WBYTES + 1);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WBYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  frame_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [7:0]        len_q, len_d;
  logic [7:0]        widx_q, widx_d;
  logic [BC_W-1:0]   bcnt_q, bcnt_d;
  logic              wr_q, wr_d;
  logic              burst_q, burst_d;
  logic              err_q, err_d;
  logic              go_q, go_d;

  logic              s_hs;
  logic              last_word;
  logic              bus_done;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_err;
  logic              ser_load;
  logic [DATA_W-1:0] ser_word;
  logic [CNT_W-1:0]  ser_cnt;
  logic              ser_done;

  assign s_tready  = (state_q == ST_OPC) || (state_q == ST_ADDR) ||
                     (state_q == ST_LEN) || (state_q == ST_WDAT);
  assign s_hs      = s_tvalid && s_tready;
  assign last_word = (widx_q == (burst_q ? len_q : 8'd0));

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    len_d    = len_q;
    widx_d   = widx_q;
    bcnt_d   = bcnt_q;
    wr_d     = wr_q;
    burst_d  = burst_q;
    err_d    = err_q;
    go_d     = 1'b0;
    ser_load = 1'b0;
    ser_word = '0;
    ser_cnt  = '0;
    case (state_q)
      ST_OPC: begin
        if (s_hs) begin
          if (opc_known(s_tdata)) begin
            wr_d    = (s_tdata == OPC_WR_ONE) || (s_tdata == OPC_WR_BURST);
            burst_d = (s_tdata == OPC_WR_BURST) || (s_tdata == OPC_RD_BURST);
            bcnt_d  = '0;
            widx_d  = '0;
            err_d   = 1'b0;
            state_d = ST_ADDR;
          end else begin
            ser_load = 1'b1;
            ser_word = {RESP_FAIL, {(DATA_W-8){1'b0}}};
            ser_cnt  = CNT_W'(1);
            state_d  = ST_STAT;
          end
        end
      end
      ST_ADDR: begin
        if (s_hs) begin
          addr_d = {addr_q[ADDR_W-9:0], s_tdata};
          bcnt_d = bcnt_q + BC_W'(1);
          if (bcnt_q == BC_W'(ABYTES - 1)) begin
            bcnt_d  = '0;
            state_d = ST_LEN;
          end
        end
      end
      ST_LEN: begin
        if (s_hs) begin
          len_d = s_tdata;
          if (wr_q) begin
            state_d = ST_WDAT;
          end else begin
            go_d    = 1'b1;
            state_d = ST_BUS;
          end
        end
      end
      ST_WDAT: begin
        if (s_hs) begin
          wdata_d = {wdata_q[DATA_W-9:0], s_tdata};
          bcnt_d  = bcnt_q + BC_W'(1);
          if (bcnt_q == BC_W'(WBYTES - 1)) begin
            bcnt_d  = '0;
            go_d    = 1'b1;
            state_d = ST_BUS;
          end
        end
      end
      ST_BUS: begin
        if (bus_done) begin
          err_d = err_q | bus_err;
          if (!wr_q) begin
            ser_load = 1'b1;
            ser_word = bus_rdata;
            ser_cnt  = CNT_W'(WBYTES);
            state_d  = ST_RDOUT;
          end else if (last_word) begin
            ser_load = 1'b1;
            ser_word = {status_code(err_q | bus_err), {(DATA_W-8){1'b0}}};
            ser_cnt  = CNT_W'(1);
            state_d  = ST_STAT;
          end else begin
            addr_d  = addr_q + ADDR_STEP;
            widx_d  = widx_q + 8'd1;
            state_d = ST_WDAT;
          end
        end
      end
      ST_RDOUT: begin
        if (ser_done) begin
          if (last_word) begin
            ser_load = 1'b1;
            ser_word = {status_code(err_q), {(DATA_W-8){1'b0}}};
            ser_cnt  = CNT_W'(1);
            state_d  = ST_STAT;
          end else begin
            addr_d  = addr_q + ADDR_STEP;
            widx_d  = widx_q + 8'd1;
            go_d    = 1'b1;
            state_d = ST_BUS;
          end
        end
      end
      ST_STAT: begin
        if (ser_done) state_d = ST_OPC;
      end
      default: state_d = ST_OPC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPC;
      addr_q  <= '0;
      wdata_q <= '0;
      len_q   <= '0;
      widx_q  <= '0;
      bcnt_q  <= '0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      err_q   <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      len_q   <= len_d;
      widx_q  <= widx_d;
      bcnt_q  <= bcnt_d;
      wr_q    <= wr_d;
      burst_q <= burst_d;
      err_q   <= err_d;
      go_q    <= go_d;
    end
  end

  cmdbr_apb_master #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_apb (
    .clk       (clk),
    .rst_n     (rst_ni),
    .start     (go_q),
    .req_addr  (addr_q),
    .req_write (wr_q),
    .req_wdata (wdata_q),
    .done      (bus_done),
    .rsp_rdata (bus_rdata),
    .rsp_err   (bus_err),
    .paddr     (paddr),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .pready    (pready),
    .pslverr   (pslverr)
  );

  cmdbr_resp_ser #(
    .DATA_W (DATA_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_ni),
    .load      (ser_load),
    .load_word (ser_word),
    .load_cnt  (ser_cnt),
    .done      (ser_done),
    .m_tdata   (m_tdata),
    .m_tvalid  (m_tvalid),
    .m_tready  (m_tready)
  );

  // R9: input refused while bus or response path is busy
  p_busy_blocks_input_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (psel || m_tvalid) |-> !s_tready);

  // R8: unknown operation byte answered at once with 0xEE, no bus cycle
  p_bad_opcode_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_OPC && s_hs && !opc_known(s_tdata)) |=>
      (m_tvalid && m_tdata == RESP_FAIL && !psel));

  // R1: nothing driven on the bus or the response port after reset until a frame arrives
  p_quiet_in_opc_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_OPC) |-> (!psel && !m_tvalid));

endmodule

// File: tb/cmd_bus_bridge_tb.sv
module cmd_bus_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  s_tdata;
  logic        s_tvalid;
  logic        s_tready;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tready;
  logic [31:0] paddr;
  logic        psel, penable, pwrite;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;

  always #2.5 clk = ~clk;

  cmd_bus_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0]  exp_bytes[$];
  string       exp_tags[$];
  bit          exp_w[$];
  logic [31:0] exp_a[$];
  logic [31:0] exp_d[$];

  logic [31:0] model [64];
  logic [31:0] smem  [64];
  logic [31:0] wbuf  [256];

  int   ws = 0;
  bit   bp_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  int   wcnt = 0;
  bit   saw_setup = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] init_word(input int i);
    return {8'h5A, 8'(i), ~8'(i), 8'hC3};
  endfunction

  // response monitor / scoreboard, plus backpressure on the response port
  always @(negedge clk) begin
    if (rst_n) begin
      if (bp_mode) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        m_tready = lfsr[0] & lfsr[2];
      end else begin
        m_tready = 1'b1;
      end
      if (m_tvalid && m_tready) begin
        if (exp_bytes.size() == 0) begin
          chk(1'b0, "R8", "unexpected response byte", 32'(m_tdata), 32'h0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_bytes.pop_front();
          t = exp_tags.pop_front();
          chk(m_tdata == e, t, "response byte", 32'(m_tdata), 32'(e));
        end
      end
      if (psel || m_tvalid)
        chk(!s_tready, "R9", "s_tready while busy", 32'(s_tready), 32'h0);
    end
  end

  // APB slave model with wait states and an error region at 0xE0000000..0xEFFFFFFF
  always @(negedge clk) begin
    if (!rst_n || !psel) begin
      pready = 1'b0; pslverr = 1'b0; wcnt = 0; saw_setup = 0;
    end else if (!penable) begin
      saw_setup = 1;
      pready = 1'b0;
    end else if (wcnt < ws) begin
      wcnt++;
      pready = 1'b0;
    end else if (!pready) begin
      bit bad;
      bad = (paddr[31:28] == 4'hE);
      pready  = 1'b1;
      pslverr = bad;
      prdata  = bad ? 32'hDEAD_BEEF : smem[paddr[7:2]];
      if (pwrite && !bad) smem[paddr[7:2]] = pwdata;
      chk(saw_setup, "R6", "setup phase before access", 32'(saw_setup), 32'h1);
      if (exp_w.size() == 0) begin
        chk(1'b0, "R8", "unexpected APB transfer", paddr, 32'h0);
      end else begin
        bit ew;
        logic [31:0] ea, ed;
        ew = exp_w.pop_front(); ea = exp_a.pop_front(); ed = exp_d.pop_front();
        chk(pwrite == ew, "R2", "APB direction", 32'(pwrite), 32'(ew));
        chk(paddr == ea, "R5", "APB address", paddr, ea);
        if (ew) chk(pwdata == ed, "R3", "APB write data", pwdata, ed);
      end
    end
  end

  task automatic expect_byte(input logic [7:0] b, input string tag);
    exp_bytes.push_back(b);
    exp_tags.push_back(tag);
  endtask

  task automatic send_byte(input logic [7:0] b);
    s_tdata  = b;
    s_tvalid = 1'b1;
    while (!s_tready) @(negedge clk);
    @(negedge clk);
    s_tvalid = 1'b0;
  endtask

  task automatic send_head(input logic [7:0] op, input logic [31:0] a, input logic [7:0] len);
    send_byte(op);
    send_byte(a[31:24]); send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    send_byte(len);
  endtask

  task automatic run_write(input logic [7:0] op, input logic [31:0] a, input logic [7:0] len);
    int nw;
    bit err;
    logic [31:0] ad;
    nw  = (op == 8'h03) ? int'(len) + 1 : 1;
    err = 0;
    for (int i = 0; i < nw; i++) begin
      ad = a + 32'(4 * i);
      exp_w.push_back(1'b1); exp_a.push_back(ad); exp_d.push_back(wbuf[i]);
      if (ad[31:28] == 4'hE) err = 1;
      else model[ad[7:2]] = wbuf[i];
    end
    expect_byte(err ? 8'hEE : 8'hAC, err ? "R7" : "R3");
    send_head(op, a, len);
    for (int i = 0; i < nw; i++) begin
      send_byte(wbuf[i][31:24]); send_byte(wbuf[i][23:16]);
      send_byte(wbuf[i][15:8]);  send_byte(wbuf[i][7:0]);
    end
  endtask

  task automatic run_read(input logic [7:0] op, input logic [31:0] a, input logic [7:0] len);
    int nw;
    bit err;
    logic [31:0] ad, w;
    nw  = (op == 8'h04) ? int'(len) + 1 : 1;
    err = 0;
    for (int i = 0; i < nw; i++) begin
      ad = a + 32'(4 * i);
      exp_w.push_back(1'b0); exp_a.push_back(ad); exp_d.push_back(32'h0);
      if (ad[31:28] == 4'hE) begin err = 1; w = 32'hDEAD_BEEF; end
      else w = model[ad[7:2]];
      expect_byte(w[31:24], "R4"); expect_byte(w[23:16], "R4");
      expect_byte(w[15:8], "R4");  expect_byte(w[7:0], "R4");
    end
    expect_byte(err ? 8'hEE : 8'hAC, err ? "R7" : "R4");
    send_head(op, a, len);
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((exp_bytes.size() != 0 || exp_w.size() != 0) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    chk(exp_bytes.size() == 0, "R9", "response bytes outstanding", 32'(exp_bytes.size()), 32'h0);
    chk(s_tready == 1'b1, "R9", "back to operation wait", 32'(s_tready), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; s_tvalid = 1'b0; s_tdata = 8'h00; m_tready = 1'b1;
    pready = 1'b0; pslverr = 1'b0; prdata = 32'h0;
    for (int i = 0; i < 64; i++) begin
      model[i] = init_word(i);
      smem[i]  = init_word(i);
    end
    for (int i = 0; i < 256; i++) wbuf[i] = {8'(i), 8'h3C, ~8'(i), 8'(i * 7)};
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!psel && !penable, "R1", "bus idle in reset", {30'h0, psel, penable}, 32'h0);
    chk(!m_tvalid, "R1", "m_tvalid in reset", 32'(m_tvalid), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(s_tready, "R1", "s_tready after reset", 32'(s_tready), 32'h1);
    chk(!psel && !m_tvalid, "R1", "quiet after reset", {30'h0, psel, m_tvalid}, 32'h0);

    // R2/R3: single write
    wbuf[0] = 32'hCAFE_F00D;
    run_write(8'h01, 32'h0000_0010, 8'h00);
    drain();
    // R4: single read, length byte 0x05 must be ignored
    run_read(8'h02, 32'h0000_0010, 8'h05);
    drain();
    // R5: burst write of 4 words with bus wait states
    ws = 2;
    for (int i = 0; i < 4; i++) wbuf[i] = 32'h1111_0000 * 32'(i + 1) + 32'(i);
    run_write(8'h03, 32'h0000_0020, 8'h03);
    drain();
    // R5/R10: burst read back under response backpressure
    bp_mode = 1;
    run_read(8'h04, 32'h0000_0020, 8'h03);
    drain();
    // R8: unknown operation byte, then a normal frame
    expect_byte(8'hEE, "R8");
    send_byte(8'h7F);
    expect_byte(8'hEE, "R8");
    send_byte(8'h00);
    run_read(8'h02, 32'h0000_0024, 8'h00);
    drain();
    // R7: single write to error region
    ws = 0;
    run_write(8'h01, 32'hE000_0000, 8'h00);
    drain();
    // R7: burst read running into error region
    run_read(8'h04, 32'hDFFF_FFF8, 8'h02);
    drain();
    // R7: burst write starting in the error region, later words still performed
    for (int i = 0; i < 2; i++) wbuf[i] = 32'hABCD_0000 + 32'(i);
    run_write(8'h03, 32'hEFFF_FFFC, 8'h01);
    drain();
    // R5: longest burst, 256 words, back-to-back frames without waiting
    bp_mode = 0;
    ws = 1;
    run_read(8'h04, 32'h0000_0000, 8'hFF);
    run_read(8'h02, 32'h0000_00FC, 8'hFF);
    drain();
    summary();
  end

endmodule